// File: doc/BRIEF.md
# Segment Selector Descriptor Loader

This block reloads one segment register. Software presents a new 16-bit selector with a one-cycle write strobe. The block takes the selector apart, picks the global or the local table, forms the entry address and checks it against the table limit. If the entry is usable, it reads the 8-byte descriptor as two 32-bit words over a memory read port. It then checks the present flag. If that succeeds, it copies base, limit, access rights and flags into a hidden cache that all later accesses read. No later access causes a table read until the next selector write.

A descriptor whose accessed flag is clear is marked accessed: a single byte is written back to memory before completion is signalled. A failed load reports a fault code and leaves the cache as it was.

Both memory ports use valid/ready. A request holds its valid signal, address and data unchanged until the cycle in which ready is high, and that cycle completes the transfer. The memory may hold ready low for any number of cycles. Read data comes back on a response strobe in some later cycle, and the block always accepts it. The response carries no back-pressure. Table bases and limits must not change while busy is high.

Top module: `seg_loader`

## Requirements
- R1: The selector is split as index = bits 15:3, table select = bit 2 (0 global, 1 local) and requested privilege = bits 1:0. The first read goes to the chosen table base plus index*8 and the second read goes to that address plus 4.
- R2: A global-table selector with index 0 faults with code 1 and issues no read. Index 0 of the local table loads normally.
- R3: If index*8+7 is greater than the chosen table limit, the load faults with code 2 and issues no read. An entry that ends exactly at the limit loads.
- R4: On success the cache holds the following fields, and cache_valid is 1. The first word supplies limit[15:0] from bits 15:0 and base[15:0] from bits 31:16. The second word supplies base[23:16] from bits 7:0, the access byte from bits 15:8, limit[19:16] from bits 19:16, the flags from bits 23:20 and base[31:24] from bits 31:24. cache_sel holds the selector that was written.
- R5: If the access byte bit 7 (present) is 0, the load faults with code 3 and the cache keeps its previous contents.
- R6: If access bit 0 (accessed) is 0, exactly one byte write of the access byte with bit 0 set goes to entry address plus 5 before done, and the cache stores the byte with bit 0 set. If the bit is already 1, no write is made.
- R7: busy is high from the cycle after the selector write until the cycle in which a one-cycle done or fault pulse appears. A selector write while busy is ignored. A write in the done cycle starts a new load.
- R8: rd_valid and rd_addr are held steady while rd_ready is low, and loads complete correctly under read back-pressure.
- R9: A synchronous active-high reset leaves the cache invalid. While the cache is invalid, use_req raises use_fault. After a successful load, use_fault stays low.
- R10: Segment uses (use_req) never start a memory read. No read is made outside a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| sel_wr | input | 1 | selector write strobe |
| sel_in | input | 16 | new selector |
| gtab_base | input | 32 | global table base |
| gtab_limit | input | 16 | global table limit |
| ltab_base | input | 32 | local table base |
| ltab_limit | input | 16 | local table limit |
| rd_valid | output | 1 | read request valid |
| rd_ready | input | 1 | read request accepted |
| rd_addr | output | 32 | read word address |
| rsp_valid | input | 1 | read data strobe |
| rsp_data | input | 32 | read data |
| wr_valid | output | 1 | byte write valid |
| wr_ready | input | 1 | byte write accepted |
| wr_addr | output | 32 | byte write address |
| wr_byte | output | 8 | byte write data |
| busy | output | 1 | load in progress |
| done | output | 1 | load succeeded (pulse) |
| fault | output | 1 | load failed (pulse) |
| fault_code | output | 2 | 1 null, 2 bounds, 3 not present |
| use_req | input | 1 | segment use through the cache |
| use_fault | output | 1 | use with invalid cache |
| cache_valid | output | 1 | cache holds a descriptor |
| cache_sel | output | 16 | selector in the cache |
| cache_base | output | 32 | segment base |
| cache_limit | output | 20 | segment limit |
| cache_access | output | 8 | access-rights byte |
| cache_flags | output | 4 | granularity/size/available flags |

## Verification
Two events can fall in the same cycle: the done pulse of one load and the selector write of the next. The bench drives a new selector write during the done cycle. It then checks three things: a second load runs, the cache first shows the earlier descriptor, and the cache ends with the later one. A second overlap is a selector write made while a load is busy. The bench writes a selector that would fault, and checks that the running load still completes with done and the original selector.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_NULL   = 2'd1,
    FLT_BOUNDS = 2'd2,
    FLT_ABSENT = 2'd3
  } flt_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic [7:0]  access;
    logic [3:0]  flags;
  } seg_cache_t;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int LIM_W  = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] gbase,
  input  logic [LIM_W-1:0]  glimit,
  input  logic [ADDR_W-1:0] lbase,
  input  logic [LIM_W-1:0]  llimit,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              is_null,
  output logic              out_of_bounds
);
  localparam int IDX_W = SEL_W - 3;
  localparam int OFF_W = IDX_W + 4;

  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [OFF_W-1:0]  last_off;
  logic [OFF_W-1:0]  lim_ext;

  always_comb begin
    idx        = sel[SEL_W-1:3];
    use_local  = sel[2];
    last_off   = {1'b0, idx, 3'b111};
    lim_ext    = OFF_W'(use_local ? llimit : glimit);
    entry_addr = (use_local ? lbase : gbase) + ADDR_W'({idx, 3'b000});
    is_null    = !use_local && (idx == '0);
    out_of_bounds = last_off > lim_ext;
  end
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_pkg::*;
(
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  output seg_cache_t  fields,
  output logic        present,
  output logic        accessed
);
  always_comb begin
    fields.limit  = {hi[19:16], lo[15:0]};
    fields.base   = {hi[31:24], hi[7:0], lo[31:16]};
    fields.access = hi[15:8];
    fields.flags  = hi[23:20];
    present       = hi[15];
    accessed      = hi[8];
  end
endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic              is_null,
  input  logic              out_of_bounds,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic              present,
  input  logic              accessed,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_byte,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              busy,
  output logic              accept,
  output logic              commit,
  output logic              done,
  output logic              fault,
  output flt_e              fault_code
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int AR_OFFSET  = 5;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD0, S_RS0, S_RD1, S_RS1, S_EVAL, S_WB} st_e;
  st_e st;

  always_comb begin
    busy     = st != S_IDLE;
    accept   = (st == S_IDLE) && sel_wr;
    rd_valid = (st == S_RD0) || (st == S_RD1);
    rd_addr  = entry_addr + ((st == S_RD1) ? ADDR_W'(WORD_BYTES) : '0);
    wr_valid = st == S_WB;
    wr_addr  = entry_addr + ADDR_W'(AR_OFFSET);
    wr_byte  = hi_q[15:8] | 8'h01;
    commit   = ((st == S_EVAL) && present && accessed) || ((st == S_WB) && wr_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      lo_q       <= '0;
      hi_q       <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      done  <= commit;
      fault <= 1'b0;
      unique case (st)
        S_IDLE: if (sel_wr) st <= S_CHK;
        S_CHK: begin
          if (is_null) begin
            fault <= 1'b1; fault_code <= FLT_NULL; st <= S_IDLE;
          end else if (out_of_bounds) begin
            fault <= 1'b1; fault_code <= FLT_BOUNDS; st <= S_IDLE;
          end else begin
            fault_code <= FLT_NONE; st <= S_RD0;
          end
        end
        S_RD0: if (rd_ready) st <= S_RS0;
        S_RS0: if (rsp_valid) begin lo_q <= rsp_data; st <= S_RD1; end
        S_RD1: if (rd_ready) st <= S_RS1;
        S_RS1: if (rsp_valid) begin hi_q <= rsp_data; st <= S_EVAL; end
        S_EVAL: begin
          if (!present) begin
            fault <= 1'b1; fault_code <= FLT_ABSENT; st <= S_IDLE;
          end else if (!accessed) st <= S_WB;
          else st <= S_IDLE;
        end
        S_WB: if (wr_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R8
  AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHK) && is_null |=> !rd_valid && fault); // R2
  AST_OOB_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHK) && !is_null && out_of_bounds |=> !rd_valid && fault); // R3
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R7
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int LIM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [LIM_W-1:0]  gtab_limit,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [LIM_W-1:0]  ltab_limit,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_byte,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  input  logic              use_req,
  output logic              use_fault,
  output logic              cache_valid,
  output logic [SEL_W-1:0]  cache_sel,
  output logic [31:0]       cache_base,
  output logic [19:0]       cache_limit,
  output logic [7:0]        cache_access,
  output logic [3:0]        cache_flags
);
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] entry_addr;
  logic              is_null, oob, present, accessed, accept, commit;
  logic [DATA_W-1:0] lo_q, hi_q;
  seg_cache_t        dec, cache_q;
  flt_e              fcode;

  seg_addr_gen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .LIM_W(LIM_W)) u_addr (
    .sel(sel_q), .gbase(gtab_base), .glimit(gtab_limit),
    .lbase(ltab_base), .llimit(ltab_limit),
    .entry_addr(entry_addr), .is_null(is_null), .out_of_bounds(oob)
  );

  seg_desc_decode u_dec (
    .lo(lo_q), .hi(hi_q), .fields(dec), .present(present), .accessed(accessed)
  );

  seg_fetch_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .is_null(is_null), .out_of_bounds(oob),
    .entry_addr(entry_addr), .present(present), .accessed(accessed),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .lo_q(lo_q), .hi_q(hi_q), .busy(busy), .accept(accept), .commit(commit),
    .done(done), .fault(fault), .fault_code(fcode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      cache_q     <= '0;
      cache_valid <= 1'b0;
      cache_sel   <= '0;
    end else begin
      if (accept) sel_q <= sel_in;
      if (commit) begin
        cache_q           <= dec;
        cache_q.access[0] <= 1'b1;
        cache_valid       <= 1'b1;
        cache_sel         <= sel_q;
      end
    end
  end

  always_comb begin
    fault_code   = fcode;
    use_fault    = use_req && !cache_valid;
    cache_base   = cache_q.base;
    cache_limit  = cache_q.limit;
    cache_access = cache_q.access;
    cache_flags  = cache_q.flags;
  end

  AST_FAULT_KEEPS_CACHE: assert property (@(posedge clk) disable iff (rst)
    fault |-> $stable(cache_q) && $stable(cache_valid) && $stable(cache_sel)); // R5
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> cache_valid && !busy); // R4
  AST_DONE_ACCESSED: assert property (@(posedge clk) disable iff (rst)
    done |-> cache_access[0] && cache_access[7]); // R6
  AST_USE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_valid && !wr_valid); // R10
endmodule

// File: tb/seg_loader_tb.sv
module seg_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic sel_wr = 0; logic [15:0] sel_in = 0;
  logic [31:0] gtab_base = 32'h0, ltab_base = 32'h80;
  logic [15:0] gtab_limit = 16'h3F, ltab_limit = 16'h1F;
  logic rd_valid, rd_ready = 1, rsp_valid = 0; logic [31:0] rd_addr, rsp_data = 0;
  logic wr_valid, wr_ready = 1; logic [31:0] wr_addr; logic [7:0] wr_byte;
  logic busy, done, fault, use_req = 0, use_fault, cache_valid;
  logic [1:0] fault_code; logic [15:0] cache_sel; logic [31:0] cache_base;
  logic [19:0] cache_limit; logic [7:0] cache_access; logic [3:0] cache_flags;

  logic [7:0] mem [0:255];
  int rd_cnt = 0, wr_cnt = 0; logic [31:0] first_rd, last_wa; logic [7:0] last_wb;
  logic stall_en = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_loader u_dut (.*);

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    rd_ready  <= stall_en ? ~rd_ready : 1'b1;
    if (rd_valid && rd_ready) begin
      if (rd_cnt == 0) first_rd <= rd_addr;
      rd_cnt    <= rd_cnt + 1;
      rsp_valid <= 1'b1;
      rsp_data  <= {mem[rd_addr[7:0]+8'd3], mem[rd_addr[7:0]+8'd2],
                    mem[rd_addr[7:0]+8'd1], mem[rd_addr[7:0]]};
    end
    if (wr_valid && wr_ready) begin
      wr_cnt <= wr_cnt + 1; last_wa <= wr_addr; last_wb <= wr_byte;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic put_desc(input int a, input logic [31:0] b, input logic [19:0] l,
                          input logic [7:0] ar, input logic [3:0] fl);
    mem[a] = l[7:0]; mem[a+1] = l[15:8]; mem[a+2] = b[7:0]; mem[a+3] = b[15:8];
    mem[a+4] = b[23:16]; mem[a+5] = ar; mem[a+6] = {fl, l[19:16]}; mem[a+7] = b[31:24];
  endtask

  task automatic start_load(input logic [15:0] s);
    sel_in = s; sel_wr = 1; @(negedge clk); sel_wr = 0;
  endtask

  task automatic wait_result(output bit ok, output logic [1:0] code);
    ok = 0; code = 0;
    for (int i = 0; i < 100; i++) begin
      if (done || fault) begin ok = done; code = fault_code; return; end
      @(negedge clk);
    end
    chk(0, "watchdog", 0, 1);
  endtask

  task automatic load(input logic [15:0] s, output bit ok, output logic [1:0] code,
                      output int nrd, output int nwr);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt; rd_cnt = 0;
    start_load(s); wait_result(ok, code);
    nrd = rd_cnt; nwr = wr_cnt - w0; rd_cnt = r0 + nrd;
  endtask

  task automatic t_reset();
    use_req = 1; @(negedge clk);
    chk(!cache_valid, "R9 reset invalid", cache_valid, 0);
    chk(use_fault, "R9 use before load", use_fault, 1);
    chk(!busy, "R7 idle after reset", busy, 0);
    use_req = 0;
  endtask

  task automatic t_gdt_basic();
    bit ok; logic [1:0] c; int nr, nw;
    load(16'h000B, ok, c, nr, nw);
    chk(ok, "R4 done", c, 0);
    chk(first_rd == 32'h8, "R1 first addr", first_rd, 8);
    chk(nr == 2, "R1 two reads", nr, 2);
    chk(cache_base == 32'h12345678, "R4 base", cache_base, 32'h12345678);
    chk(cache_limit == 20'hABCDE, "R4 limit", cache_limit, 20'hABCDE);
    chk(cache_access == 8'h93 && cache_flags == 4'hC, "R4 access/flags",
        {cache_flags, cache_access}, 12'hC93);
    chk(cache_sel == 16'h000B, "R4 selector", cache_sel, 16'h000B);
    chk(nw == 0, "R6 no write when accessed", nw, 0);
    use_req = 1; #1;
    chk(!use_fault, "R9 use after load", use_fault, 0);
    use_req = 0;
  endtask

  task automatic t_writeback();
    bit ok; logic [1:0] c; int nr, nw;
    load(16'h0010, ok, c, nr, nw);
    chk(ok && nw == 1, "R6 one write", nw, 1);
    chk(last_wa == 32'd21 && last_wb == 8'h9B, "R6 write addr/byte",
        {last_wa[23:0], last_wb}, {24'd21, 8'h9B});
    chk(cache_access == 8'h9B, "R6 cache access", cache_access, 8'h9B);
    chk(cache_base == 32'hCAFEF00D && cache_limit == 20'h00FFF, "R4 base/limit 2",
        cache_base, 32'hCAFEF00D);
  endtask

  task automatic t_absent();
    bit ok; logic [1:0] c; int nr, nw;
    load(16'h0018, ok, c, nr, nw);
    chk(!ok && c == 2'd3, "R5 fault code 3", c, 3);
    chk(cache_base == 32'hCAFEF00D && cache_sel == 16'h0010, "R5 cache kept",
        cache_base, 32'hCAFEF00D);
  endtask

  task automatic t_null();
    bit ok; logic [1:0] c; int nr, nw;
    load(16'h0003, ok, c, nr, nw);
    chk(!ok && c == 2'd1, "R2 null code", c, 1);
    chk(nr == 0, "R2 no read", nr, 0);
    load(16'h0007, ok, c, nr, nw);
    chk(ok, "R2 local index 0 allowed", ok, 1);
    chk(first_rd == 32'h80, "R1 local table addr", first_rd, 32'h80);
    chk(cache_base == 32'h0BAD0000 && cache_flags == 4'h8, "R4 local fields",
        cache_base, 32'h0BAD0000);
  endtask

  task automatic t_bounds();
    bit ok; logic [1:0] c; int nr, nw;
    load(16'h0040, ok, c, nr, nw);
    chk(!ok && c == 2'd2 && nr == 0, "R3 global beyond limit", {c, nr[7:0]}, {2'd2, 8'd0});
    load(16'h0038, ok, c, nr, nw);
    chk(ok && first_rd == 32'd56, "R3 entry at limit loads", first_rd, 56);
    load(16'h0024, ok, c, nr, nw);
    chk(!ok && c == 2'd2 && nr == 0, "R3 local beyond limit", {c, nr[7:0]}, {2'd2, 8'd0});
    load(16'h001C, ok, c, nr, nw);
    chk(ok && first_rd == 32'h98, "R3 local last entry", first_rd, 32'h98);
  endtask

  task automatic t_stall();
    bit ok; logic [1:0] c; int nr, nw;
    stall_en = 1;
    load(16'h0012, ok, c, nr, nw);
    stall_en = 0;
    chk(ok && nr == 2, "R8 stalled load", nr, 2);
    chk(cache_base == 32'hCAFEF00D && cache_sel == 16'h0012, "R8 stalled data",
        cache_base, 32'hCAFEF00D);
  endtask

  task automatic t_busy();
    bit ok; logic [1:0] c;
    start_load(16'h000B);
    chk(busy, "R7 busy after write", busy, 1);
    sel_in = 16'h0040; sel_wr = 1; @(negedge clk); sel_wr = 0;
    wait_result(ok, c);
    chk(ok && !busy, "R7 write while busy ignored", {ok, busy}, 2'b10);
    chk(cache_sel == 16'h000B, "R7 original selector", cache_sel, 16'h000B);
    start_load(16'h0038);
    chk(cache_sel == 16'h000B, "R7 cache before second", cache_sel, 16'h000B);
    wait_result(ok, c);
    chk(ok && cache_sel == 16'h0038, "R7 write in done cycle", cache_sel, 16'h0038);
  endtask

  task automatic t_uses();
    int r0;
    r0 = rd_cnt; use_req = 1;
    repeat (10) @(negedge clk);
    use_req = 0;
    chk(rd_cnt == r0 && !busy, "R10 uses do not fetch", rd_cnt - r0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put_desc(8,    32'h12345678, 20'hABCDE, 8'h93, 4'hC);
    put_desc(16,   32'hCAFEF00D, 20'h00FFF, 8'h9A, 4'h4);
    put_desc(24,   32'h11111111, 20'h00010, 8'h12, 4'h0);
    put_desc(56,   32'h00007777, 20'h00001, 8'h93, 4'h0);
    put_desc(8'h80, 32'h0BAD0000, 20'h12345, 8'hF3, 4'h8);
    put_desc(8'h98, 32'h44440000, 20'h00100, 8'h93, 4'h4);
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_gdt_basic(); t_writeback(); t_absent(); t_null();
    t_bounds(); t_stall(); t_busy(); t_uses();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule